// File: doc/BRIEF.md
# Byte-Code Fetch and Execute Sequencer

This block steps through a stream of byte codes held in a read-only program memory. A 16-bit program counter addresses that memory. The block runs a small accumulator instruction set:

- loading an 8-bit value into the accumulator or into one of eight working registers,
- adding a register or an inline constant to the accumulator,
- a short jump relative to the next instruction.

Each instruction is one or two bytes long. Every byte code outside this set is stepped over as a one-byte no-operation.

The program memory port is synchronous. An address issued in one cycle returns its byte in the next cycle. The sequencer spends two cycles on each byte: one to issue the address and one to consume the data. The accumulator is visible at the ports. A one-cycle completion strobe marks each retired instruction, and the accumulator and fetch address are already updated when the strobe is high.

Top module: `byte_seq_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the fetch address is 0000h and the accumulator is 00h. All eight working registers read back as 00h.
- R2: Code 74h followed by a data byte puts that byte in the accumulator.
- R3: Code 78h+n (n in 0..7) followed by a data byte writes that byte into working register n, and leaves the accumulator unchanged.
- R4: Code 28h+n is one byte long and adds working register n to the accumulator, modulo 256.
- R5: Code 24h followed by a data byte adds that byte to the accumulator, modulo 256.
- R6: Code 80h followed by an offset byte moves execution to (address of the jump + 2 + the offset taken as a signed byte), modulo 65536. An offset of FEh re-executes the jump forever.
- R7: A non-jump instruction moves the fetch address forward by its length, 1 or 2, modulo 65536. Within a two-byte instruction, the data byte is read from the address after the code byte.
- R8: Any other code is one byte long and changes neither the accumulator nor the registers.
- R9: Counting from the first clock after reset, or from the previous completion strobe, the strobe rises after 2 cycles for a one-byte instruction and after 4 cycles for a two-byte instruction. The strobe is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pmem_addr | output | AW (16) | Registered program memory address |
| pmem_data | input | DW (8) | Byte returned one cycle after its address |
| acc | output | DW (8) | Accumulator |
| step_done | output | 1 | One-cycle strobe when an instruction retires |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit datapath and eight working registers. Its program memory model holds only 256 bytes and decodes the low eight address bits, so a backward jump from address 0000h lands on FFFFh and the data byte that follows is read at the wrapped address 0000h. With these values, byte-sum overflow, a jump to itself, forward and backward offsets, and 16-bit counter wraparound are all reached by short programs.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int RIDX_W = 3;

  typedef enum logic [1:0] {
    ST_ISSUE_OP,
    ST_TAKE_OP,
    ST_ISSUE_ARG,
    ST_TAKE_ARG
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NOP,
    K_LDR,
    K_LDA,
    K_ADDR,
    K_ADDI,
    K_JMP
  } op_kind_t;

  typedef struct packed {
    op_kind_t          kind;
    logic              two_byte;
    logic [RIDX_W-1:0] ridx;
  } op_info_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb begin
    info.ridx     = op[RIDX_W-1:0];
    info.kind     = K_NOP;
    info.two_byte = 1'b0;
    casez (op)
      8'b0111_1???: begin info.kind = K_LDR;  info.two_byte = 1'b1; end
      8'h74:        begin info.kind = K_LDA;  info.two_byte = 1'b1; end
      8'b0010_1???: begin info.kind = K_ADDR; info.two_byte = 1'b0; end
      8'h24:        begin info.kind = K_ADDI; info.two_byte = 1'b1; end
      8'h80:        begin info.kind = K_JMP;  info.two_byte = 1'b1; end
      default:      begin info.kind = K_NOP;  info.two_byte = 1'b0; end
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic [RIDX_W-1:0] ridx,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && (widx == RIDX_W'(g))) regs[g] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/seq_pc_calc.sv
module seq_pc_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] offset,
  output logic [AW-1:0] pc_p1,
  output logic [AW-1:0] pc_p2,
  output logic [AW-1:0] jmp_tgt
);
  localparam int EXT_W = AW - DW;

  logic [AW-1:0] off_sx;

  assign off_sx  = {{EXT_W{offset[DW-1]}}, offset};
  assign pc_p1   = pc + AW'(1);
  assign pc_p2   = pc + AW'(2);
  assign jmp_tgt = pc_p2 + off_sx;
endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core
  import seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] pmem_addr,
  input  logic [DW-1:0] pmem_data,
  output logic [DW-1:0] acc,
  output logic          step_done
);
  seq_state_t    state;
  logic [AW-1:0] pc;
  logic [DW-1:0] op_q;
  logic [DW-1:0] cur_op;
  op_info_t      info;
  logic [DW-1:0] reg_rd;
  logic          reg_we;
  logic [AW-1:0] pc_p1, pc_p2, jmp_tgt, next_pc;

  // code byte is live on the bus in the take cycle, held afterwards
  assign cur_op = (state == ST_TAKE_OP) ? pmem_data : op_q;

  seq_decode i_dec (
    .op   (cur_op[7:0]),
    .info (info)
  );

  assign reg_we = (state == ST_TAKE_ARG) && (info.kind == K_LDR);

  seq_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .widx  (info.ridx),
    .wdata (pmem_data),
    .ridx  (info.ridx),
    .rdata (reg_rd)
  );

  seq_pc_calc #(.AW(AW), .DW(DW)) i_pc (
    .pc      (pc),
    .offset  (pmem_data),
    .pc_p1   (pc_p1),
    .pc_p2   (pc_p2),
    .jmp_tgt (jmp_tgt)
  );

  assign next_pc = (info.kind == K_JMP) ? jmp_tgt : pc_p2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ISSUE_OP;
      pc        <= '0;
      pmem_addr <= '0;
      acc       <= '0;
      op_q      <= '0;
      step_done <= 1'b0;
    end else begin
      step_done <= 1'b0;
      case (state)
        ST_ISSUE_OP: state <= ST_TAKE_OP;
        ST_TAKE_OP: begin
          op_q <= pmem_data;
          if (info.two_byte) begin
            pmem_addr <= pc_p1;
            state     <= ST_ISSUE_ARG;
          end else begin
            if (info.kind == K_ADDR) acc <= acc + reg_rd;
            pc        <= pc_p1;
            pmem_addr <= pc_p1;
            step_done <= 1'b1;
            state     <= ST_ISSUE_OP;
          end
        end
        ST_ISSUE_ARG: state <= ST_TAKE_ARG;
        ST_TAKE_ARG: begin
          case (info.kind)
            K_LDA:   acc <= pmem_data;
            K_ADDI:  acc <= acc + pmem_data;
            default: ;
          endcase
          pc        <= next_pc;
          pmem_addr <= next_pc;
          step_done <= 1'b1;
          state     <= ST_ISSUE_OP;
        end
        default: state <= ST_ISSUE_OP;
      endcase
    end
  end
endmodule

// File: rtl/byte_seq_core_chk.sv
module byte_seq_core_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pmem_addr,
  input logic [DW-1:0] acc,
  input logic          step_done
);
  // R1: reset leaves the fetch address and accumulator at zero
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pmem_addr == '0 && acc == '0));

  // R9: completion strobe lasts a single cycle
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done);

  // R8: accumulator only moves when an instruction retires
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step_done |-> $stable(acc));

  // R9: every address stays on the bus for at least two cycles
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pmem_addr) |=> $stable(pmem_addr));

  // R7: a mid-instruction address move steps to the following byte
  assert_arg_next_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_done && !$stable(pmem_addr)) |-> pmem_addr == AW'($past(pmem_addr) + AW'(1)));
endmodule

bind byte_seq_core byte_seq_core_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .pmem_addr (pmem_addr),
  .acc       (acc),
  .step_done (step_done)
);

// File: tb/test_byte_seq_core.sv
module test_byte_seq_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] pmem_addr;
  logic [DW-1:0] pmem_data;
  logic [DW-1:0] acc;
  logic          step_done;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  logic [DW-1:0] q_acc  [$];
  logic [AW-1:0] q_addr [$];
  int            q_len  [$];
  string         q_tag  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous program memory, one cycle latency, low 8 address bits decoded
  always @(posedge clk) pmem_data <= mem[pmem_addr[7:0]];

  byte_seq_core i_byte_seq_core (
    .clk       (clk),
    .rst       (rst),
    .pmem_addr (pmem_addr),
    .pmem_data (pmem_data),
    .acc       (acc),
    .step_done (step_done)
  );

  task automatic expect_step(input logic [DW-1:0] a, input logic [AW-1:0] ad,
                             input int len, input string tag);
    q_acc.push_back(a);
    q_addr.push_back(ad);
    q_len.push_back(len);
    q_tag.push_back(tag);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic check_reset();
    @(negedge clk);
    checks++;
    if (pmem_addr !== 16'h0000 || acc !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: addr=%h acc=%h expected addr=0000 acc=00", pmem_addr, acc);
    end
  endtask

  task automatic run_and_drain();
    @(negedge clk);
    #1 rst = 1'b0;
    while (q_acc.size() != 0) @(negedge clk);
    @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // monitor: every retired instruction is compared with the head of the queue.
  // Each item checks the accumulator, the next fetch address (R7) and the
  // retire spacing (R9).
  always @(negedge clk) begin
    if (rst) cyc = 0;
    else begin
      cyc++;
      if (step_done) begin
        if (q_acc.size() != 0) begin
          logic [DW-1:0] ea;
          logic [AW-1:0] ead;
          int            el;
          string         et;
          ea  = q_acc.pop_front();
          ead = q_addr.pop_front();
          el  = q_len.pop_front();
          et  = q_tag.pop_front();
          checks++;
          if (acc !== ea || pmem_addr !== ead || cyc != el) begin
            errors++;
            $display("FAIL %s: acc=%h addr=%h cycles=%0d expected acc=%h addr=%h cycles=%0d",
                     et, acc, pmem_addr, cyc, ea, ead, el);
          end
        end
        cyc = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);

    // Test A: loads, register adds, immediate add, self jump
    clear_mem();
    mem[8'h00] = 8'h7D; mem[8'h01] = 8'h25;
    mem[8'h02] = 8'h7F; mem[8'h03] = 8'h34;
    mem[8'h04] = 8'h74; mem[8'h05] = 8'h00;
    mem[8'h06] = 8'h2D;
    mem[8'h07] = 8'h2F;
    mem[8'h08] = 8'h24; mem[8'h09] = 8'h12;
    mem[8'h0A] = 8'h80; mem[8'h0B] = 8'hFE;
    check_reset();
    expect_step(8'h00, 16'h0002, 4, "R3");
    expect_step(8'h00, 16'h0004, 4, "R3");
    expect_step(8'h00, 16'h0006, 4, "R2");
    expect_step(8'h25, 16'h0007, 2, "R4");
    expect_step(8'h59, 16'h0008, 2, "R4");
    expect_step(8'h6B, 16'h000A, 4, "R5");
    expect_step(8'h6B, 16'h000A, 4, "R6");
    expect_step(8'h6B, 16'h000A, 4, "R6");
    run_and_drain();

    // Test B: cleared registers, byte wrap, unknown codes, forward/back jumps
    clear_mem();
    mem[8'h00] = 8'h2B;
    mem[8'h01] = 8'h74; mem[8'h02] = 8'hF0;
    mem[8'h03] = 8'h24; mem[8'h04] = 8'h20;
    mem[8'h05] = 8'h78; mem[8'h06] = 8'hC8;
    mem[8'h07] = 8'h7C; mem[8'h08] = 8'h77;
    mem[8'h09] = 8'h28;
    mem[8'h0A] = 8'h2C;
    mem[8'h0B] = 8'hA5;
    mem[8'h0C] = 8'h00;
    mem[8'h0D] = 8'h80; mem[8'h0E] = 8'h03;
    mem[8'h0F] = 8'h74; mem[8'h10] = 8'hFF; mem[8'h11] = 8'h00;
    mem[8'h12] = 8'h80; mem[8'h13] = 8'hEC;
    check_reset();
    expect_step(8'h00, 16'h0001, 2, "R1");
    expect_step(8'hF0, 16'h0003, 4, "R2");
    expect_step(8'h10, 16'h0005, 4, "R5");
    expect_step(8'h10, 16'h0007, 4, "R3");
    expect_step(8'h10, 16'h0009, 4, "R3");
    expect_step(8'hD8, 16'h000A, 2, "R4");
    expect_step(8'h4F, 16'h000B, 2, "R4");
    expect_step(8'h4F, 16'h000C, 2, "R8");
    expect_step(8'h4F, 16'h000D, 2, "R8");
    expect_step(8'h4F, 16'h0012, 4, "R6");
    expect_step(8'h4F, 16'h0000, 4, "R6");
    expect_step(8'h4F, 16'h0001, 2, "R9");
    run_and_drain();

    // Test C: backward jump past zero, data byte read at wrapped address
    clear_mem();
    mem[8'h00] = 8'h80; mem[8'h01] = 8'hFD;
    mem[8'h02] = 8'h24; mem[8'h03] = 8'h01;
    mem[8'hFF] = 8'h74;
    check_reset();
    expect_step(8'h00, 16'hFFFF, 4, "R6");
    expect_step(8'h80, 16'h0001, 4, "R7");
    expect_step(8'h80, 16'h0002, 2, "R8");
    expect_step(8'h81, 16'h0004, 4, "R5");
    run_and_drain();

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, pending=%0d expected 0", q_acc.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule